// File: doc/BRIEF.md
# Sixteen-Line Port and Control Register Bank

This block is a bank of 16-bit registers that sits on a simple single-cycle register bus. A write is taken on the clock edge where the write strobe is high. Read data is combinational and appears in the same cycle as the read strobe. The bank holds six plain storage registers for mode, card detect, card control and the three interrupt words (routing, mask and status). It also holds a power register with a forcing rule and a fixed card status word. These registers only store values. No interrupt or card logic acts on them here.

The rest of the bank is a sixteen-line general-purpose port with a direction word and a level word. A line drives its output only when its direction bit is 1. Each input pin copies its new value into its level bit when it changes. Every bus write to the direction word or to the level word produces a one-cycle strobe. The strobe marks the output lines whose masked value moved since the previous such write.

Top module: `pio_regbank`

## Requirements
- R1: Only address bits 5:0 are decoded, and higher address bits are ignored. The word slots are: 0x00 mode, 0x04 card detect, 0x08 card status, 0x0C power, 0x10 card control, 0x14 interrupt routing, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, 0x24 level, 0x28 level (alias). An offset whose bits 1:0 are not 00 is unmapped.
- R2: Only bits 15:0 of the write data are stored. The six plain slots (0x00, 0x04, 0x10, 0x14, 0x18, 0x1C) read back exactly what was last written to them. The interrupt words have no clear-on-write behaviour.
- R3: A write to 0x0C with data bit 7 set stores the data ORed with 0x8040. A write with bit 7 clear stores the data unchanged.
- R4: The card status slot 0x08 always reads 0x0002, and writes to it change nothing.
- R5: A write to 0x24 or 0x28 stores the data ANDed with the direction word held before that edge into the level word. Reads of either offset return the level word.
- R6: pin_out always equals the level word ANDed with the direction word. A line whose direction bit is 0 drives 0.
- R7: After the edge of a direction or level write, pin_changed holds, for one cycle, the XOR of the new masked word (level AND direction after that edge) with the word recorded at the previous such write. The recorded word then becomes the new masked word. Recording starts from 0 at reset. In every other cycle pin_changed is 0. Pin edges alone neither raise pin_changed nor update the recorded word.
- R8: pin_in is sampled on every edge. Each bit that differs from its sample at the previous edge is copied into the level word, whatever that line's direction bit. The sample register starts at 0 after reset.
- R9: A pin change and a level write in the same cycle give pin-changed bits their pin value and all other bits the masked bus value. A direction or level write in the same cycle as pin edges computes pin_changed from the resulting level word.
- R10: A read of an unmapped offset returns 0, and bus_rdata is 0 whenever bus_rd is low. A write to an unmapped offset changes no register.
- R11: After reset every register reads 0 except card status (0x0002), and pin_out and pin_changed are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte address, low 6 bits decoded |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | WDATA_W (32) | Write data, low 16 bits used |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | REG_W (16) | Combinational read data |
| pin_in | input | REG_W (16) | Port input lines |
| pin_out | output | REG_W (16) | Port output lines, masked by direction |
| pin_changed | output | REG_W (16) | One-cycle strobe of output lines changed by a port write |

## Verification
Two events can land in the same cycle: a bus write to the level or direction word, and an edge on pin_in. The bench provokes this by changing pin_in on the same falling edge where it raises bus_wr. It uses overlapping and disjoint bit patterns, so that some bits take the pin value and others take the masked bus value. It then judges the level word read back at both alias offsets, pin_out, and the strobe word against an arithmetic model. In that model the pin value wins only on the bits that actually changed.

// File: rtl/pio_pkg.sv
// Package: shared constants for the port and control register bank.
// Assumes 16-bit registers and word-aligned slot offsets in a 64-byte window.
package pio_pkg;
    localparam int unsigned REG_W      = 16;
    localparam int unsigned DEC_BITS   = 6;
    localparam int unsigned NUM_SLOTS  = 11;

    // Slot numbers (byte offset divided by four).
    localparam int unsigned SLOT_MODE    = 0;
    localparam int unsigned SLOT_DETECT  = 1;
    localparam int unsigned SLOT_STATUS  = 2;
    localparam int unsigned SLOT_POWER   = 3;
    localparam int unsigned SLOT_CARDCTL = 4;
    localparam int unsigned SLOT_ROUTE   = 5;
    localparam int unsigned SLOT_IMASK   = 6;
    localparam int unsigned SLOT_ISTAT   = 7;
    localparam int unsigned SLOT_DIR     = 8;
    localparam int unsigned SLOT_LVL_A   = 9;
    localparam int unsigned SLOT_LVL_B   = 10;

    localparam int unsigned PLAIN_N      = 6;
    localparam logic [15:0] STATUS_VALUE = 16'h0002;
    localparam int unsigned PWR_TRIG_BIT = 7;
    localparam logic [15:0] PWR_FORCE    = 16'h8040;

    // Maps a plain-storage index to its slot number.
    function automatic int unsigned plain_slot(input int unsigned g);
        case (g)
            0:       return SLOT_MODE;
            1:       return SLOT_DETECT;
            2:       return SLOT_CARDCTL;
            3:       return SLOT_ROUTE;
            4:       return SLOT_IMASK;
            default: return SLOT_ISTAT;
        endcase
    endfunction
endpackage

// File: rtl/pio_decode.sv
// Module: address decoder. Turns a byte address into a slot number and a hit flag.
// Assumes only the low DEC_BITS bits matter and slots are 32-bit aligned.
module pio_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DEC_BITS = pio_pkg::DEC_BITS,
    localparam int unsigned IDX_W   = DEC_BITS - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    import pio_pkg::*;

    logic [DEC_BITS-1:0] off;

    // Keep the decoded window only; fold away the rest.
    assign off = addr[DEC_BITS-1:0];
    assign idx = off[DEC_BITS-1:2];

    // A slot hits when aligned and inside the populated range.
    always_comb begin
        hit = (off[1:0] == 2'b00) && (int'(idx) < int'(NUM_SLOTS));
    end

    generate
        if (ADDR_W > DEC_BITS) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^addr[ADDR_W-1:DEC_BITS];
        end
    endgenerate
endmodule

// File: rtl/pio_ctrl_store.sv
// Module: control storage. Plain read/write words plus the power word.
// Assumes wr_en is already qualified by a decode hit.
module pio_ctrl_store #(
    parameter int unsigned REG_W = pio_pkg::REG_W,
    parameter int unsigned IDX_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [IDX_W-1:0]                     idx,
    input  logic [REG_W-1:0]                     wdata,
    output logic [pio_pkg::PLAIN_N-1:0][REG_W-1:0] plain_q,
    output logic [REG_W-1:0]                     power_q
);
    import pio_pkg::*;

    genvar g;
    generate
        for (g = 0; g < int'(PLAIN_N); g++) begin : g_plain
            // Plain storage word: load on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    plain_q[g] <= '0;
                end else if (wr_en && (idx == IDX_W'(plain_slot(g)))) begin
                    plain_q[g] <= wdata;
                end
            end
        end
    endgenerate

    // Power word: a set trigger bit forces the fixed extra bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            power_q <= '0;
        end else if (wr_en && (idx == IDX_W'(SLOT_POWER))) begin
            if (wdata[PWR_TRIG_BIT]) begin
                power_q <= wdata | REG_W'(PWR_FORCE);
            end else begin
                power_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/pio_port.sv
// Module: general-purpose port. Holds direction and level, samples input pins,
// masks outputs and raises the changed-lines strobe after port writes.
// Assumes pin_in is already synchronous to clk.
module pio_port #(
    parameter int unsigned LINES = pio_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_wr,
    input  logic             lvl_wr,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] pin_in,
    output logic [LINES-1:0] dir_q,
    output logic [LINES-1:0] lvl_q,
    output logic [LINES-1:0] pin_seen_q,
    output logic [LINES-1:0] pin_out,
    output logic [LINES-1:0] pin_changed
);
    logic [LINES-1:0] pin_edge;
    logic [LINES-1:0] lvl_bus;
    logic [LINES-1:0] lvl_nxt;
    logic [LINES-1:0] dir_nxt;
    logic [LINES-1:0] masked_nxt;
    logic [LINES-1:0] recorded_q;

    assign pin_edge = pin_in ^ pin_seen_q;

    // Next-state of the port words; per-line pin edges override bus data.
    always_comb begin
        lvl_bus    = lvl_wr ? (wdata & dir_q) : lvl_q;
        dir_nxt    = dir_wr ? wdata : dir_q;
        lvl_nxt    = (lvl_bus & ~pin_edge) | (pin_in & pin_edge);
        masked_nxt = lvl_nxt & dir_nxt;
    end

    // Port state: sample pins, update level and direction words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_seen_q <= '0;
            lvl_q      <= '0;
            dir_q      <= '0;
        end else begin
            pin_seen_q <= pin_in;
            lvl_q      <= lvl_nxt;
            dir_q      <= dir_nxt;
        end
    end

    // Change strobe: compare against the word recorded at the last port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recorded_q  <= '0;
            pin_changed <= '0;
        end else if (dir_wr || lvl_wr) begin
            recorded_q  <= masked_nxt;
            pin_changed <= masked_nxt ^ recorded_q;
        end else begin
            pin_changed <= '0;
        end
    end

    assign pin_out = lvl_q & dir_q;
endmodule

// File: rtl/pio_regbank.sv
// Module: top of the register bank. Decodes the bus, routes writes to the
// control store and the port, and multiplexes read data.
// Assumes single-cycle access: write on the edge, read data combinational.
module pio_regbank #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned WDATA_W = 32,
    parameter int unsigned REG_W   = pio_pkg::REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [WDATA_W-1:0] bus_wdata,
    input  logic               bus_rd,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [REG_W-1:0]   pin_in,
    output logic [REG_W-1:0]   pin_out,
    output logic [REG_W-1:0]   pin_changed
);
    import pio_pkg::*;

    localparam int unsigned IDX_W = DEC_BITS - 2;

    logic                          dec_hit;
    logic [IDX_W-1:0]              dec_idx;
    logic                          wr_ok;
    logic                          dir_wr;
    logic                          lvl_wr;
    logic [REG_W-1:0]              wdata16;
    logic [PLAIN_N-1:0][REG_W-1:0] plain_q;
    logic [REG_W-1:0]              power_q;
    logic [REG_W-1:0]              dir_q;
    logic [REG_W-1:0]              lvl_q;
    logic [REG_W-1:0]              pin_seen_q;

    pio_decode #(.ADDR_W(ADDR_W), .DEC_BITS(DEC_BITS)) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    assign wdata16 = bus_wdata[REG_W-1:0];
    assign wr_ok   = bus_wr && dec_hit;
    assign dir_wr  = wr_ok && (dec_idx == IDX_W'(SLOT_DIR));
    assign lvl_wr  = wr_ok && ((dec_idx == IDX_W'(SLOT_LVL_A)) ||
                               (dec_idx == IDX_W'(SLOT_LVL_B)));

    generate
        if (WDATA_W > REG_W) begin : g_wide
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[WDATA_W-1:REG_W];
        end
    endgenerate

    pio_ctrl_store #(.REG_W(REG_W), .IDX_W(IDX_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .idx     (dec_idx),
        .wdata   (wdata16),
        .plain_q (plain_q),
        .power_q (power_q)
    );

    pio_port #(.LINES(REG_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .dir_wr      (dir_wr),
        .lvl_wr      (lvl_wr),
        .wdata       (wdata16),
        .pin_in      (pin_in),
        .dir_q       (dir_q),
        .lvl_q       (lvl_q),
        .pin_seen_q  (pin_seen_q),
        .pin_out     (pin_out),
        .pin_changed (pin_changed)
    );

    // Read multiplexer: zero unless a mapped slot is read.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && dec_hit) begin
            for (int g = 0; g < int'(PLAIN_N); g++) begin
                if (dec_idx == IDX_W'(plain_slot(g))) begin
                    bus_rdata = plain_q[g];
                end
            end
            if (dec_idx == IDX_W'(SLOT_STATUS)) bus_rdata = REG_W'(STATUS_VALUE);
            if (dec_idx == IDX_W'(SLOT_POWER))  bus_rdata = power_q;
            if (dec_idx == IDX_W'(SLOT_DIR))    bus_rdata = dir_q;
            if (dec_idx == IDX_W'(SLOT_LVL_A) ||
                dec_idx == IDX_W'(SLOT_LVL_B))  bus_rdata = lvl_q;
        end
    end
endmodule

// File: rtl/pio_regbank_chk.sv
// Module: assertion checker for pio_regbank, attached by bind below.
// Assumes default 16-bit registers and a 6-bit decoded window.
module pio_regbank_chk #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned WDATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [WDATA_W-1:0] bus_wdata,
    input logic               bus_rd,
    input logic [15:0]        bus_rdata,
    input logic [15:0]        pin_in,
    input logic [15:0]        pin_out,
    input logic [15:0]        pin_changed,
    input logic [15:0]        dir_q,
    input logic [15:0]        lvl_q,
    input logic [15:0]        pin_seen_q,
    input logic [15:0]        power_q
);
    logic [5:0]  off;
    logic        mapped;
    logic        port_wr;
    logic [15:0] w16;

    assign off     = bus_addr[5:0];
    assign mapped  = (off[1:0] == 2'b00) && (off[5:2] <= 4'd10);
    assign w16     = bus_wdata[15:0];
    assign port_wr = bus_wr && (off == 6'h20 || off == 6'h24 || off == 6'h28);

    // Power trigger forces bits 15 and 6 on the following cycle.
    p_power_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == 6'h0C && w16[7]) |=> (power_q[15] && power_q[6]));

    // Card status read is fixed.
    p_status_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && off == 6'h08) |-> (bus_rdata == 16'h0002));

    // Unmapped or idle reads return zero.
    p_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && mapped) |-> (bus_rdata == 16'h0000));

    // A direction write leaves no output on lines it sets as inputs.
    p_dir_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == 6'h20) |=> ((pin_out & ~$past(w16)) == 16'h0000));

    // The strobe only follows a port write.
    p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_changed != 16'h0000) |-> $past(port_wr));

    // Changed pins land in the level word.
    p_pin_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((lvl_q ^ $past(pin_in)) & $past(pin_in ^ pin_seen_q)) == 16'h0000));

    // A level write with no pin edge keeps inputs-only lines clear.
    p_level_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (off == 6'h24 || off == 6'h28) && (pin_in == pin_seen_q))
        |=> (lvl_q == ($past(w16) & $past(dir_q))));
endmodule

bind pio_regbank pio_regbank_chk #(.ADDR_W(ADDR_W), .WDATA_W(WDATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_changed (pin_changed),
    .dir_q       (dir_q),
    .lvl_q       (lvl_q),
    .pin_seen_q  (pin_seen_q),
    .power_q     (power_q)
);

// File: tb/test_pio_regbank.sv
`timescale 1ns/1ps
module test_pio_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_changed;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [15:0] m_reg [0:15];
    logic [15:0] m_pwr, m_dir, m_lvl, m_prev, m_seen;

    always #2 clk = ~clk;

    pio_regbank i_pio_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_changed(pin_changed)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        logic [5:0] off = a[5:0];
        if (off[1:0] != 2'b00) return 16'h0;
        case (off[5:2])
            4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd7: return m_reg[off[5:2]];
            4'd2:        return 16'h0002;
            4'd3:        return m_pwr;
            4'd8:        return m_dir;
            4'd9, 4'd10: return m_lvl;
            default:     return 16'h0;
        endcase
    endfunction

    // Read at a negedge and compare with the model.
    task automatic rd(input logic [7:0] a, input string tag);
        bus_addr = a;
        bus_rd = 1'b1;
        #1;
        check(tag, bus_rdata, exp_read(a));
        bus_rd = 1'b0;
        #1;
        check({tag, " rd-idle"}, bus_rdata, 16'h0);
    endtask

    // One cycle: optional write plus pin value, then check strobe and outputs.
    task automatic op(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [15:0] pins, input string tag);
        logic [5:0]  off = a[5:0];
        logic        mapped = (off[1:0] == 2'b00) && (off[5:2] <= 4'd10);
        logic [15:0] w = d[15:0];
        logic [15:0] edg = pins ^ m_seen;
        logic        dirw = wr && mapped && off[5:2] == 4'd8;
        logic        lvlw = wr && mapped && (off[5:2] == 4'd9 || off[5:2] == 4'd10);
        logic [15:0] bl, nl, nd, exp_s;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = wr; pin_in = pins;
        bl = lvlw ? (w & m_dir) : m_lvl;
        nl = (bl & ~edg) | (pins & edg);
        nd = dirw ? w : m_dir;
        exp_s = 16'h0;
        if (dirw || lvlw) begin
            exp_s = (nl & nd) ^ m_prev;
            m_prev = nl & nd;
        end
        m_lvl = nl; m_dir = nd; m_seen = pins;
        if (wr && mapped) begin
            case (off[5:2])
                4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd7: m_reg[off[5:2]] = w;
                4'd3: m_pwr = w[7] ? (w | 16'h8040) : w;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0;
        check({tag, " R7 strobe"}, pin_changed, exp_s);
        check({tag, " R6 pin_out"}, pin_out, m_lvl & m_dir);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = 16'h0;
        m_pwr = 0; m_dir = 0; m_lvl = 0; m_prev = 0; m_seen = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state, R4 status value
        for (int s = 0; s < 16; s++) rd(8'(s * 4), "R11 reset read");
        check("R11 pin_out", pin_out, 16'h0);
        check("R11 pin_changed", pin_changed, 16'h0);

        // R2 plain storage with wide write data; R1 upper address bits ignored
        for (int s = 0; s < 8; s++) begin
            if (s == 2 || s == 3) continue;
            op(1'b1, 8'(8'hC0 | (s * 4)), 32'hDEAD_0000 | (32'(s) * 32'h1111 + 32'h0F0F),
               16'h0, "R2 plain write");
            rd(8'(s * 4), "R2 plain readback");
            rd(8'(8'h40 | (s * 4)), "R1 alias high address");
        end
        // R2 interrupt status holds value, no clear on writing ones
        op(1'b1, 8'h1C, 32'h0000_FFFF, 16'h0, "R2 istat set");
        op(1'b1, 8'h1C, 32'h0000_00F0, 16'h0, "R2 istat rewrite");
        rd(8'h1C, "R2 istat no clear");

        // R3 power forcing
        op(1'b1, 8'h0C, 32'h0000_0080, 16'h0, "R3 bit7");
        check("R3 power 0x80", exp_read(8'h0C), 16'h80C0);
        rd(8'h0C, "R3 power read");
        op(1'b1, 8'h0C, 32'hFFFF_1234, 16'h0, "R3 no bit7");
        rd(8'h0C, "R3 power plain");
        op(1'b1, 8'h0C, 32'h0000_00FF, 16'h0, "R3 bit7 low byte");
        rd(8'h0C, "R3 power 0xFF");
        op(1'b1, 8'h0C, 32'h0000_0000, 16'h0, "R3 zero");
        rd(8'h0C, "R3 power zero");

        // R4 status ignores writes
        op(1'b1, 8'h08, 32'h0000_FFFF, 16'h0, "R4 status write");
        rd(8'h08, "R4 status fixed");

        // R10 unmapped and misaligned writes ignored
        for (int o = 44; o < 64; o += 4) begin
            op(1'b1, 8'(o), 32'h0000_BEEF, 16'h0, "R10 unmapped write");
            rd(8'(o), "R10 unmapped read");
        end
        op(1'b1, 8'h01, 32'h0000_7777, 16'h0, "R10 misaligned write");
        rd(8'h01, "R10 misaligned read");
        rd(8'h00, "R10 slot0 intact");
        op(1'b1, 8'h22, 32'h0000_FFFF, 16'h0, "R10 misaligned dir");
        rd(8'h20, "R10 dir intact");

        // R5 / R6 / R7 sweep of direction and level patterns
        for (int i = 0; i < 32; i++) begin
            logic [15:0] d;
            d = (i < 16) ? (16'h1 << i) : ((16'hFFFF >> (i - 16)) ^ 16'(i * 16'h1357));
            op(1'b1, 8'h20, {16'hA5A5, d}, 16'h0, "R7 dir sweep");
            for (int j = 0; j < 8; j++) begin
                logic [15:0] l;
                l = {d[7:0], d[15:8]} ^ 16'(j * 16'h2493) ^ 16'hC3A5;
                op(1'b1, (j[0] ? 8'h28 : 8'h24), {16'h5A5A, l}, 16'h0, "R5 level sweep");
                rd(8'h24, "R5 level read A");
                rd(8'h28, "R5 level read B");
            end
        end

        // R8 pin edges fill level regardless of direction; no strobe
        op(1'b1, 8'h20, 32'h0, 16'h0, "R8 dir clear");
        op(1'b0, 8'h0, 32'h0, 16'hF00D, "R8 pins up");
        rd(8'h24, "R8 level from pins");
        op(1'b0, 8'h0, 32'h0, 16'h0F0D, "R8 pins partial");
        rd(8'h28, "R8 level follows");
        op(1'b1, 8'h20, 32'h0000_FF00, 16'h0F0D, "R8 dir then out");
        op(1'b0, 8'h0, 32'h0, 16'hFFFF, "R8 pins all");
        op(1'b1, 8'h24, 32'h0000_0F00, 16'hFFFF, "R7 stale record");
        rd(8'h24, "R5 level after");

        // R9 same-cycle pin edge and port write
        op(1'b1, 8'h20, 32'h0000_FFFF, 16'h0000, "R9 prep dir");
        op(1'b1, 8'h24, 32'h0000_0000, 16'h0000, "R9 prep lvl");
        op(1'b1, 8'h24, 32'h0000_00FF, 16'h0F0F, "R9 overlap");
        rd(8'h24, "R9 level merge");
        op(1'b1, 8'h28, 32'h0000_FFFF, 16'h0000, "R9 falling pins");
        rd(8'h28, "R9 level merge fall");
        op(1'b1, 8'h20, 32'h0000_00F0, 16'h8001, "R9 dir with edge");
        rd(8'h20, "R9 dir read");
        rd(8'h24, "R9 level read");

        // R11 reset again clears everything
        @(negedge clk); rst_n = 1'b0; pin_in = 16'h0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) m_reg[i] = 16'h0;
        m_pwr = 0; m_dir = 0; m_lvl = 0; m_prev = 0; m_seen = 0;
        @(negedge clk);
        for (int s = 0; s < 11; s++) rd(8'(s * 4), "R11 re-reset read");
        check("R11 pin_out after reset", pin_out, 16'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule